// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block picks the interrupt that a processor should service next when the order of service is set by software and not by the source numbers. Its input is a table of forty priority slots. Each slot names one source. The slot position sets the rank, and slot 0 is the most urgent. The block also takes the vector of sources that are both pending and enabled, and a steering vector that sends each source to the fast-interrupt class (FIQ) or to the normal-interrupt class (IRQ).

The resolver walks the slot table once for each class. In each class it finds the lowest-numbered slot whose source is live and is steered to that class. Both winners go into one 32-bit status word, and each winner has its own valid flag. Software reads this word to learn which source to handle in each class without scanning the pending bits itself. The table, the masking and the interrupt lines themselves live outside this block.

A parameter adds a register after the combinational resolver. With the register the status word lags its inputs by one clock. Without it the status word follows the inputs in the same cycle.

Top module: `prio_resolver`

## Requirements
- R1: A slot takes part in resolution only when bit 31 of its 32-bit slot word is 1. A slot whose bit 31 is 0 never produces a winner.
- R2: The source ID of a slot is bits 5:0 of its slot word. A slot whose ID is 40 to 63 is ignored even when bit 31 is set, and a valid winner ID is always below 40.
- R3: A usable slot matches the FIQ class when bit ID of the pending-enabled vector is 1 and bit ID of the steering vector is 1. It matches the IRQ class when that pending bit is 1 and the steering bit is 0. No slot matches both classes.
- R4: Within each class the matching slot with the lowest index wins, whatever the ID values held in the higher slots.
- R5: The status word carries the FIQ winner ID in bits 5:0 with its valid flag in bit 15. It carries the IRQ winner ID in bits 21:16 with its valid flag in bit 31.
- R6: A class with no matching slot reads ID 0x3F with a valid flag of 0. When no slot matches in either class the status word is 0x003F003F.
- R7: Status bits 14:6 and 30:22 always read 0.
- R8: Bits 30:6 of a slot word have no effect on the result.
- R9: A source ID may appear in several slots. Only the lowest matching slot decides the winner, and the duplicates raise no error.
- R10: The FIQ and IRQ winners are resolved independently in the same evaluation. A winner in one class does not change the result of the other class.
- R11: With REG_OUT=1 (the default), status_o shows the result for the inputs sampled at the previous rising clock edge. While rst_n is low, status_o reads 0x003F003F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset for the output register |
| pend_en_i | input | NUM_SRC (40) | Sources that are both pending and enabled, one bit per source ID |
| fiq_sel_i | input | NUM_SRC (40) | Class steering per source: 1 sends it to FIQ, 0 sends it to IRQ |
| slot_tbl_i | input | NUM_SLOTS*32 (1280) | Slot words. Slot k occupies bits 32k+31 to 32k |
| status_o | output | 32 | Packed FIQ and IRQ winner word |

## Verification
The FIQ search and the IRQ search always run in the same evaluation over one shared slot table, so the main risk is that the two classes interfere with each other. The bench provokes this with random steering vectors that split the live sources between the two classes. It adds directed tables in which a high-rank slot of one class sits just above a lower-rank slot of the other class. Every clock, each half of the status word is compared against a slot-walking reference model. That model keeps a separate found flag for each class, so a stolen or swapped winner shows up as a miscompare in exactly one half.

// File: rtl/pr_pkg.sv
package pr_pkg;

  localparam int ID_W      = 6;
  localparam int SLOT_W    = 32;
  localparam int STAT_W    = 32;
  localparam int VALID_BIT = SLOT_W - 1;
  localparam logic [ID_W-1:0] NONE_ID = '1;

  // Field positions of the packed status word.
  localparam int FIQ_ID_LSB = 0;
  localparam int FIQ_FLAG   = 15;
  localparam int IRQ_ID_LSB = 16;
  localparam int IRQ_FLAG   = 31;

  localparam logic [STAT_W-1:0] IDLE_WORD = 32'h003F_003F;

  typedef struct packed {
    logic            found;
    logic [ID_W-1:0] id;
  } winner_t;

  // A slot word can only take part when its valid bit is set and its ID names a real source.
  function automatic logic slot_usable(input logic [SLOT_W-1:0] w, input int n_src);
    return w[VALID_BIT] && (int'(w[ID_W-1:0]) < n_src);
  endfunction

  function automatic logic [ID_W-1:0] slot_id(input logic [SLOT_W-1:0] w);
    return w[ID_W-1:0];
  endfunction

  // Pack both winners into one status word; a missing winner reads NONE_ID.
  function automatic logic [STAT_W-1:0] pack_status(input winner_t f, input winner_t q);
    logic [STAT_W-1:0] s;
    s = '0;
    s[FIQ_ID_LSB +: ID_W] = f.found ? f.id : NONE_ID;
    s[FIQ_FLAG]           = f.found;
    s[IRQ_ID_LSB +: ID_W] = q.found ? q.id : NONE_ID;
    s[IRQ_FLAG]           = q.found;
    return s;
  endfunction

endpackage

// File: rtl/pr_slot_decode.sv
module pr_slot_decode
  import pr_pkg::*;
#(
  parameter int NUM_SRC   = 40,
  parameter int NUM_SLOTS = 40
) (
  input  logic [NUM_SRC-1:0]          pend_en_i,
  input  logic [NUM_SRC-1:0]          fiq_sel_i,
  input  logic [NUM_SLOTS*SLOT_W-1:0] slot_tbl_i,
  output logic [NUM_SLOTS-1:0]        fiq_hit_o,
  output logic [NUM_SLOTS-1:0]        irq_hit_o,
  output logic [NUM_SLOTS*ID_W-1:0]   slot_ids_o
);

  localparam int ID_SPACE = 1 << ID_W;

  // Pad the source vectors up to the full ID space so that any 6-bit ID indexes a real bit.
  logic [ID_SPACE-1:0] pend_pad;
  logic [ID_SPACE-1:0] sel_pad;

  assign pend_pad = {{(ID_SPACE-NUM_SRC){1'b0}}, pend_en_i};
  assign sel_pad  = {{(ID_SPACE-NUM_SRC){1'b0}}, fiq_sel_i};

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic [SLOT_W-1:0] word;
    logic [ID_W-1:0]   id;
    logic              usable;
    logic              live;

    assign word   = slot_tbl_i[k*SLOT_W +: SLOT_W];
    assign id     = slot_id(word);
    assign usable = slot_usable(word, NUM_SRC);
    assign live   = usable && pend_pad[id];

    assign fiq_hit_o[k] = live &&  sel_pad[id];
    assign irq_hit_o[k] = live && !sel_pad[id];
    assign slot_ids_o[k*ID_W +: ID_W] = id;
  end

endmodule

// File: rtl/pr_first_hit.sv
module pr_first_hit
  import pr_pkg::*;
#(
  parameter int NUM_SLOTS = 40
) (
  input  logic [NUM_SLOTS-1:0]      hit_i,
  input  logic [NUM_SLOTS*ID_W-1:0] ids_i,
  output logic [NUM_SLOTS-1:0]      pick_o,
  output winner_t                   win_o
);

  // Keep only the lowest set bit: the carry chain of the two's complement gives slot-0-first priority.
  assign pick_o = hit_i & (~hit_i + NUM_SLOTS'(1));

  logic [ID_W-1:0] id_acc;

  always_comb begin
    id_acc = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (pick_o[k]) id_acc = id_acc | ids_i[k*ID_W +: ID_W];
    end
  end

  assign win_o.found = |hit_i;
  assign win_o.id    = id_acc;

endmodule

// File: rtl/pr_status_pack.sv
module pr_status_pack
  import pr_pkg::*;
(
  input  winner_t           fiq_win_i,
  input  winner_t           irq_win_i,
  output logic [STAT_W-1:0] status_o
);

  assign status_o = pack_status(fiq_win_i, irq_win_i);

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import pr_pkg::*;
#(
  parameter int NUM_SRC   = 40,
  parameter int NUM_SLOTS = 40,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0]          pend_en_i,
  input  logic [NUM_SRC-1:0]          fiq_sel_i,
  input  logic [NUM_SLOTS*SLOT_W-1:0] slot_tbl_i,
  output logic [STAT_W-1:0]           status_o
);

  localparam int N_CLS = 2;

  // Per-slot match vectors, one per class; these are brought out as named wires for the checker.
  logic [NUM_SLOTS-1:0]      fiq_hit;
  logic [NUM_SLOTS-1:0]      irq_hit;
  logic [NUM_SLOTS*ID_W-1:0] slot_ids;

  pr_slot_decode #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS)) u_decode (
    .pend_en_i (pend_en_i),
    .fiq_sel_i (fiq_sel_i),
    .slot_tbl_i(slot_tbl_i),
    .fiq_hit_o (fiq_hit),
    .irq_hit_o (irq_hit),
    .slot_ids_o(slot_ids)
  );

  logic [NUM_SLOTS-1:0] cls_hit  [N_CLS];
  logic [NUM_SLOTS-1:0] cls_pick [N_CLS];
  winner_t              cls_win  [N_CLS];

  assign cls_hit[0] = fiq_hit;
  assign cls_hit[1] = irq_hit;

  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    pr_first_hit #(.NUM_SLOTS(NUM_SLOTS)) u_find (
      .hit_i (cls_hit[c]),
      .ids_i (slot_ids),
      .pick_o(cls_pick[c]),
      .win_o (cls_win[c])
    );
  end

  logic [NUM_SLOTS-1:0] fiq_pick;
  logic [NUM_SLOTS-1:0] irq_pick;
  assign fiq_pick = cls_pick[0];
  assign irq_pick = cls_pick[1];

  logic [STAT_W-1:0] status_comb;

  pr_status_pack u_pack (
    .fiq_win_i(cls_win[0]),
    .irq_win_i(cls_win[1]),
    .status_o (status_comb)
  );

  if (REG_OUT) begin : g_reg
    logic [STAT_W-1:0] status_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= IDLE_WORD;
      else        status_q <= status_comb;
    end
    assign status_o = status_q;
  end else begin : g_comb
    assign status_o = status_comb;
  end

endmodule

// File: rtl/pr_resolver_chk.sv
module pr_resolver_chk
  import pr_pkg::*;
#(
  parameter int NUM_SRC   = 40,
  parameter int NUM_SLOTS = 40,
  parameter bit REG_OUT   = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SLOTS-1:0] fiq_hit,
  input logic [NUM_SLOTS-1:0] irq_hit,
  input logic [NUM_SLOTS-1:0] fiq_pick,
  input logic [NUM_SLOTS-1:0] irq_pick,
  input logic [STAT_W-1:0]    status_comb,
  input logic [STAT_W-1:0]    status_o
);

  AST_CLASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_hit & irq_hit) == '0);  // R3

  AST_FIQ_SINGLE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fiq_pick));  // R4

  AST_IRQ_SINGLE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_pick));  // R4

  AST_FIQ_NOTHING_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((fiq_pick - NUM_SLOTS'(1)) & fiq_hit) == '0);  // R4

  AST_IRQ_NOTHING_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_pick - NUM_SLOTS'(1)) & irq_hit) == '0);  // R4

  AST_FIQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_hit == '0) |-> (status_comb[15:0] == 16'h003F));  // R6

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hit == '0) |-> (status_comb[31:16] == 16'h003F));  // R6

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_comb[14:6] == '0) && (status_comb[30:22] == '0));  // R7

  AST_FIQ_ID_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    status_comb[FIQ_FLAG] |-> (int'(status_comb[5:0]) < NUM_SRC));  // R2

  AST_IRQ_ID_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    status_comb[IRQ_FLAG] |-> (int'(status_comb[21:16]) < NUM_SRC));  // R2

  if (REG_OUT) begin : g_lat
    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (status_o == $past(status_comb)));  // R11
  end else begin : g_pass
    AST_OUT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      status_o == status_comb);  // R11
  end

endmodule

bind prio_resolver pr_resolver_chk #(
  .NUM_SRC  (NUM_SRC),
  .NUM_SLOTS(NUM_SLOTS),
  .REG_OUT  (REG_OUT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fiq_hit    (fiq_hit),
  .irq_hit    (irq_hit),
  .fiq_pick   (fiq_pick),
  .irq_pick   (irq_pick),
  .status_comb(status_comb),
  .status_o   (status_o)
);

// File: tb/prio_resolver_test.sv
`timescale 1ns/1ps
module prio_resolver_test;

  localparam int NS  = 40;
  localparam int NSL = 40;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NS-1:0]       pend = '0;
  logic [NS-1:0]       sel = '0;
  logic [31:0]         tbl [NSL];
  logic [NSL*32-1:0]   tbl_flat;
  logic [31:0]         status;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NSL; k++) tbl_flat[k*32 +: 32] = tbl[k];
  end

  prio_resolver uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_en_i (pend),
    .fiq_sel_i (sel),
    .slot_tbl_i(tbl_flat),
    .status_o  (status)
  );

  // Reference: walk slots from rank 0 upward, keep the first hit per class.
  function automatic logic [31:0] model();
    int fid = 63, iid = 63;
    bit ff = 0, fi = 0;
    for (int s = 0; s < NSL; s++) begin
      int id;
      id = int'(tbl[s] & 32'h3F);
      if (tbl[s][31] == 1'b1 && id < NS && pend[id] == 1'b1) begin
        if (sel[id] == 1'b1 && !ff) begin ff = 1; fid = id; end
        if (sel[id] == 1'b0 && !fi) begin fi = 1; iid = id; end
      end
    end
    return (ff ? 32'h8000 : 32'h0) + 32'(fid) + (fi ? 32'h8000_0000 : 32'h0) + (32'(iid) << 16);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // Inputs were set just after a falling edge; the next rising edge captures, compare at the falling edge after.
  task automatic run(input string tag);
    logic [31:0] exp;
    exp = model();
    @(negedge clk);
    check(tag, status, exp);
    check("R7 reserved bits", status & 32'h7FC0_7FC0, 32'h0);
  endtask

  task automatic clear_tbl();
    for (int k = 0; k < NSL; k++) tbl[k] = 32'h0;
  endtask

  initial begin
    clear_tbl();
    repeat (3) @(negedge clk);
    check("R11 reset value", status, 32'h003F003F);
    rst_n = 1'b1;

    // R6: valid slots but nothing pending.
    for (int k = 0; k < NSL; k++) tbl[k] = 32'h8000_0000 | 32'(k);
    run("R6 idle word");

    // R1: live sources but every slot invalid.
    for (int k = 0; k < NSL; k++) tbl[k] = 32'(k);
    pend = '1; sel = 40'h00_FFFF_0000;
    run("R1 invalid slots ignored");

    // R2: out-of-range IDs with valid bit set.
    clear_tbl();
    for (int k = 0; k < 24; k++) tbl[k] = 32'h8000_0000 | 32'(40 + k);
    tbl[30] = 32'h8000_0000 | 32'd7;
    sel = '0; sel[7] = 1'b1;
    run("R2 ids 40..63 ignored");

    // R3/R5: one FIQ and one IRQ source, field layout.
    clear_tbl(); pend = '0; sel = '0;
    tbl[3] = 32'h8000_0000 | 32'd33; tbl[5] = 32'h8000_0000 | 32'd12;
    pend[33] = 1; pend[12] = 1; sel[33] = 1;
    run("R3 R5 class steering and fields");

    // R4: lower slot wins though its ID is larger.
    tbl[1] = 32'h8000_0000 | 32'd39; pend[39] = 1; sel[39] = 1;
    tbl[2] = 32'h8000_0000 | 32'd0;  pend[0] = 1;
    run("R4 lowest slot wins");

    // R8: junk in bits 30:6 changes nothing.
    for (int k = 0; k < NSL; k++) tbl[k] = tbl[k] | 32'h7FFF_FFC0;
    run("R8 junk slot bits");

    // R9: duplicate ID in several slots.
    clear_tbl(); pend = '0; sel = '0;
    tbl[4] = 32'h8000_0009; tbl[6] = 32'h8000_0009; tbl[9] = 32'h8000_0011;
    pend[9] = 1; pend[17] = 1;
    run("R9 duplicates");

    // R10: FIQ at slot 0, IRQ at the very last slot.
    clear_tbl(); pend = '0; sel = '0;
    tbl[0] = 32'h8000_0005; tbl[NSL-1] = 32'h8000_0006;
    pend[5] = 1; pend[6] = 1; sel[5] = 1;
    run("R10 independent classes");

    // Random tables against the reference.
    for (int v = 0; v < 600; v++) begin
      for (int k = 0; k < NSL; k++) begin
        logic [31:0] r;
        r = $urandom();
        tbl[k] = (r & 32'h7FFF_FFC0) | ((r[3:0] != 0) ? 32'h8000_0000 : 32'h0)
               | ((r[7:4] < 4'd13) ? 32'($urandom_range(0, 39)) : 32'($urandom_range(40, 63)));
      end
      pend = {$urandom(), $urandom()} & ((v % 3 == 0) ? {$urandom(), $urandom()} : '1);
      if (v % 5 == 0) pend = '0;
      sel = {$urandom(), $urandom()};
      run("R3 R4 R10 random table");
    end

    // R11: reset again forces the idle word.
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset value again", status, 32'h003F003F);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule